// File: doc/BRIEF.md
# Audio Sample Input Formatter

This block sits between a bus-written common data register and a two-channel serial audio line transmitter. Every 32-bit word a bus or DMA master writes is unpacked according to the run-time configuration, and the result is delivered as a pair of channel samples. The configuration covers the byte order, the position of the valid bits inside the container, the valid-bit count, the container size, the channel count and the transfer mode. Each pair goes into a small holding FIFO. The serializer drains that FIFO through a valid/ready pop port.

The output port follows valid/ready rules. `out_valid` is high whenever the FIFO holds a pair. A pair leaves the FIFO on a clock edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_ch1` and `out_ch2` hold their values. The write side is a register write strobe and has no back-pressure. Software or DMA pace themselves on `tx_ready` and `chunk_ready`. A write that arrives while the FIFO is full is lost and is recorded in a sticky flag.

Top module: `audio_word_formatter`

## Requirements
- R1: After reset the FIFO is empty: `fifo_empty`=1, `fifo_full`=0, `out_valid`=0, `tx_ready`=1, `overflow`=0, `underrun`=0.
- R2: With `cfg_dual`=0 (mono) in indexed or toggle mode, each accepted write pushes one pair that carries the same aligned sample on both channels.
- R3: In toggle mode (`cfg_xfer_mode`=1, or 3), dual writes alternate between two channels. The first write after reset or clear goes to channel 1, the next to channel 2, and so on. The channel-2 write pushes the pair.
- R4: With `cfg_big_endian`=0, byte 0 of the container (`wr_data[7:0]`) is the least significant byte. With `cfg_big_endian`=1, it is the most significant byte. The container is the low `cfg_bytes_m1`+1 bytes of the word.
- R5: With `cfg_msb_just`=0, the sample is the low `cfg_valid_bits` bits of the container. With `cfg_msb_just`=1, it is the high `cfg_valid_bits` bits of the container.
- R6: Each output channel is 24 bits wide with the sample MSB-aligned. Samples of more than 24 bits lose their low bits. Narrower samples are zero-filled at the bottom. Container bits outside the sample have no effect.
- R7: In indexed mode (`cfg_xfer_mode`=0) with dual set, `wr_chan`=0 loads the channel-1 sample. A write with `wr_chan`=1 pushes a pair of that stored channel-1 sample and the new channel-2 sample.
- R8: In interleaved mode (`cfg_xfer_mode`=2), each write pushes one pair. Channel 1 comes from `wr_data[15:0]` and channel 2 from `wr_data[31:16]`. Each half is treated as a 2-byte container, with the valid bits capped at 16.
- R9: The FIFO holds DEPTH (4) pairs and returns them in write order. `fifo_full` is high with DEPTH pairs stored, and `tx_ready` = not full. `chunk_ready` is high when the number of free pairs is at least `cfg_chunk`.
- R10: A write while `fifo_full` is high is dropped. It sets `overflow`, which stays high until reset or clear.
- R11: A `fifo_clear` pulse empties the FIFO, returns the toggle pointer to channel 1 and clears `overflow`.
- R12: Asserting `out_ready` while `out_valid` is low raises `underrun` for exactly one cycle after that edge.
- R13: While `out_valid` is high and `out_ready` is low, the output samples stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_dual | input | 1 | 0 mono, 1 two channels |
| cfg_big_endian | input | 1 | Container byte order |
| cfg_msb_just | input | 1 | Valid bits at the container top (1) or bottom (0) |
| cfg_valid_bits | input | 6 | Valid bits per sample (8..32) |
| cfg_bytes_m1 | input | 2 | Container bytes minus one |
| cfg_xfer_mode | input | 2 | 0 indexed, 1 toggle, 2 interleaved |
| cfg_chunk | input | 4 | Free pairs needed for chunk_ready |
| fifo_clear | input | 1 | Empty the FIFO, reset the toggle pointer, clear overflow |
| wr_en | input | 1 | Data register write strobe |
| wr_chan | input | 1 | Target channel in indexed mode |
| wr_data | input | 32 | Written word |
| out_valid | output | 1 | A pair is available |
| out_ready | input | 1 | Serializer takes the pair |
| out_ch1 | output | 24 | Channel 1 sample, MSB-aligned |
| out_ch2 | output | 24 | Channel 2 sample, MSB-aligned |
| tx_ready | output | 1 | FIFO can accept a write |
| fifo_full | output | 1 | FIFO full |
| fifo_empty | output | 1 | FIFO empty |
| chunk_ready | output | 1 | At least cfg_chunk pairs free |
| overflow | output | 1 | Sticky: a write was dropped |
| underrun | output | 1 | One-cycle pulse: pop while empty |

## Verification
The alignment path is driven with words whose container holds distinct bytes. This exposes byte-order errors, and ones placed above the valid bits expose missing masks. Widths of 8, 16, 18, 20, 24 and 32 bits separate zero-fill from truncation. Justification is told apart by placing the sample at the top of a 4-byte container. Channel steering is tried in mono, toggle, indexed and interleaved modes with different values per channel, so a swapped or duplicated channel shows. A clear issued between a channel-1 and a channel-2 write shows whether the toggle pointer returns. A fill-past-full run separates dropped writes from stored ones, and checks FIFO order, the chunk threshold, the stability of a held output and the underrun pulse.

// File: rtl/awf_pkg.sv
`timescale 1ns/1ps
package awf_pkg;
  typedef enum logic [1:0] {
    XFER_INDEXED = 2'd0,
    XFER_TOGGLE  = 2'd1,
    XFER_INTERLV = 2'd2,
    XFER_TOGGLE2 = 2'd3
  } xfer_mode_e;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned SMP_W  = 24;

  // Unpack one container from a word and return a 24-bit MSB-aligned sample.
  function automatic logic [SMP_W-1:0] awf_align(
    input logic [WORD_W-1:0] w,
    input logic              big,
    input logic              msbj,
    input logic [2:0]        nbytes,
    input logic [5:0]        vbits
  );
    logic [WORD_W-1:0] rev, cont, smp, top;
    logic [5:0]        eff, cbits;
    eff   = (vbits > 6'd32) ? 6'd32 : vbits;
    cbits = {nbytes, 3'b000};
    rev   = {w[7:0], w[15:8], w[23:16], w[31:24]};
    if (big) cont = rev >> (6'd32 - cbits);
    else     cont = w & ~(32'hFFFF_FFFF << cbits);
    if (msbj && (cbits > eff)) smp = cont >> (cbits - eff);
    else                       smp = cont;
    top = smp << (6'd32 - eff);
    return top[WORD_W-1:WORD_W-SMP_W];
  endfunction
endpackage

// File: rtl/awf_fifo.sv
`timescale 1ns/1ps
module awf_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 48,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IX  = AW'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (push && !clear) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (clear) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (push) wp <= (wp == LAST_IX) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == LAST_IX) ? '0 : rp + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign dout = mem[rp];

  // R9
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);
  // R10
  push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |-> (count != FULL_CNT));
endmodule

// File: rtl/awf_steer.sv
`timescale 1ns/1ps
module awf_steer
  import awf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             wr_en,
  input  logic             wr_chan,
  input  logic [31:0]      wr_data,
  input  logic             full,
  input  logic             cfg_dual,
  input  logic             cfg_big_endian,
  input  logic             cfg_msb_just,
  input  logic [5:0]       cfg_valid_bits,
  input  logic [1:0]       cfg_bytes_m1,
  input  logic [1:0]       cfg_xfer_mode,
  output logic             push,
  output logic [SMP_W-1:0] push_ch1,
  output logic [SMP_W-1:0] push_ch2,
  output logic             next_ch2
);
  localparam int unsigned NCH = 2;
  localparam int unsigned HW  = WORD_W / NCH;

  logic             accept, is_inter, is_index, chan;
  logic [2:0]       nbytes;
  logic [5:0]       vb_half;
  logic [SMP_W-1:0] smp, stage;
  logic [SMP_W-1:0] half_smp [NCH];

  assign accept   = wr_en && !full;
  assign is_inter = (cfg_xfer_mode == XFER_INTERLV);
  assign is_index = (cfg_xfer_mode == XFER_INDEXED);
  assign chan     = is_index ? wr_chan : next_ch2;
  assign nbytes   = {1'b0, cfg_bytes_m1} + 3'd1;
  assign vb_half  = (cfg_valid_bits > 6'd16) ? 6'd16 : cfg_valid_bits;
  assign smp      = awf_align(wr_data, cfg_big_endian, cfg_msb_just, nbytes, cfg_valid_bits);

  for (genvar g = 0; g < NCH; g++) begin : g_half
    assign half_smp[g] = awf_align({{HW{1'b0}}, wr_data[g*HW +: HW]},
                                   cfg_big_endian, cfg_msb_just, 3'd2, vb_half);
  end

  always_comb begin
    push     = 1'b0;
    push_ch1 = smp;
    push_ch2 = smp;
    if (accept) begin
      if (is_inter) begin
        push     = 1'b1;
        push_ch1 = half_smp[0];
        push_ch2 = half_smp[1];
      end else if (!cfg_dual) begin
        push = 1'b1;
      end else if (chan) begin
        push     = 1'b1;
        push_ch1 = stage;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_ch2 <= 1'b0;
      stage    <= '0;
    end else if (clear) begin
      next_ch2 <= 1'b0;
    end else if (accept && !is_inter && cfg_dual) begin
      if (!chan)     stage    <= smp;
      if (!is_index) next_ch2 <= ~next_ch2;
    end
  end

  // R11
  clear_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !next_ch2);
  // R10
  drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !clear) |=> $stable(next_ch2));
endmodule

// File: rtl/audio_word_formatter.sv
`timescale 1ns/1ps
module audio_word_formatter
  import awf_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned PW   = 2 * SMP_W
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_dual,
  input  logic        cfg_big_endian,
  input  logic        cfg_msb_just,
  input  logic [5:0]  cfg_valid_bits,
  input  logic [1:0]  cfg_bytes_m1,
  input  logic [1:0]  cfg_xfer_mode,
  input  logic [3:0]  cfg_chunk,
  input  logic        fifo_clear,
  input  logic        wr_en,
  input  logic        wr_chan,
  input  logic [31:0] wr_data,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [23:0] out_ch1,
  output logic [23:0] out_ch2,
  output logic        tx_ready,
  output logic        fifo_full,
  output logic        fifo_empty,
  output logic        chunk_ready,
  output logic        overflow,
  output logic        underrun
);
  logic             push, pop, next_ch2;
  logic [SMP_W-1:0] push_ch1, push_ch2;
  logic [PW-1:0]    head;
  logic [CW-1:0]    count, free_cnt;

  awf_steer u_steer (
    .clk, .rst_n, .clear(fifo_clear), .wr_en, .wr_chan, .wr_data,
    .full(fifo_full), .cfg_dual, .cfg_big_endian, .cfg_msb_just,
    .cfg_valid_bits, .cfg_bytes_m1, .cfg_xfer_mode,
    .push, .push_ch1, .push_ch2, .next_ch2
  );

  awf_fifo #(.DEPTH(DEPTH), .W(PW)) u_fifo (
    .clk, .rst_n, .clear(fifo_clear), .push, .din({push_ch2, push_ch1}),
    .pop, .dout(head), .count
  );

  assign fifo_empty  = (count == '0);
  assign fifo_full   = (count == CW'(DEPTH));
  assign tx_ready    = !fifo_full;
  assign out_valid   = !fifo_empty;
  assign pop         = out_valid && out_ready;
  assign out_ch1     = head[SMP_W-1:0];
  assign out_ch2     = head[PW-1:SMP_W];
  assign free_cnt    = CW'(DEPTH) - count;
  assign chunk_ready = int'(free_cnt) >= int'(cfg_chunk);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overflow <= 1'b0;
      underrun <= 1'b0;
    end else begin
      underrun <= out_ready && !out_valid;
      if (fifo_clear)               overflow <= 1'b0;
      else if (wr_en && fifo_full)  overflow <= 1'b1;
    end
  end

  // R10
  overflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fifo_full && !fifo_clear) |=> overflow);
  // R11
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clear |=> (fifo_empty && !overflow));
  // R12
  underrun_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && !out_valid) |=> underrun);
  // R13
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !fifo_clear) |=> (out_valid && $stable(out_ch1) && $stable(out_ch2)));
  // R9
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_full && fifo_empty));
endmodule

// File: tb/audio_word_formatter_test.sv
`timescale 1ns/1ps
module audio_word_formatter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_dual = 1'b0, cfg_big_endian = 1'b0, cfg_msb_just = 1'b0;
  logic [5:0]  cfg_valid_bits = 6'd16;
  logic [1:0]  cfg_bytes_m1 = 2'd1, cfg_xfer_mode = 2'd1;
  logic [3:0]  cfg_chunk = 4'd1;
  logic        fifo_clear = 1'b0, wr_en = 1'b0, wr_chan = 1'b0, out_ready = 1'b0;
  logic [31:0] wr_data = '0;
  logic        out_valid, tx_ready, fifo_full, fifo_empty, chunk_ready, overflow, underrun;
  logic [23:0] out_ch1, out_ch2;
  int          n_vec = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  audio_word_formatter uut (
    .clk, .rst_n, .cfg_dual, .cfg_big_endian, .cfg_msb_just, .cfg_valid_bits,
    .cfg_bytes_m1, .cfg_xfer_mode, .cfg_chunk, .fifo_clear, .wr_en, .wr_chan,
    .wr_data, .out_valid, .out_ready, .out_ch1, .out_ch2, .tx_ready, .fifo_full,
    .fifo_empty, .chunk_ready, .overflow, .underrun
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FIL%s %s: got %h expected %h", "", tag, got, exp);
    end
  endtask

  task automatic cfg(input logic dual, input logic big, input logic msb,
                     input logic [5:0] vb, input logic [1:0] bm1, input logic [1:0] mode);
    cfg_dual = dual; cfg_big_endian = big; cfg_msb_just = msb;
    cfg_valid_bits = vb; cfg_bytes_m1 = bm1; cfg_xfer_mode = mode;
  endtask

  task automatic write(input logic [31:0] d, input logic ch);
    wr_data = d; wr_chan = ch; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pop_check(input string tag, input logic [23:0] e1, input logic [23:0] e2);
    check({tag, " valid"}, {31'b0, out_valid}, 32'd1);
    check({tag, " ch1"}, {8'b0, out_ch1}, {8'b0, e1});
    check({tag, " ch2"}, {8'b0, out_ch2}, {8'b0, e2});
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 empty", {31'b0, fifo_empty}, 32'd1);
    check("R1 full", {31'b0, fifo_full}, 32'd0);
    check("R1 valid", {31'b0, out_valid}, 32'd0);
    check("R1 tx_ready", {31'b0, tx_ready}, 32'd1);
    check("R1 overflow", {31'b0, overflow}, 32'd0);
    check("R1 underrun", {31'b0, underrun}, 32'd0);
  endtask

  task automatic t_mono();
    cfg(1'b0, 1'b0, 1'b0, 6'd16, 2'd1, 2'd1);
    write(32'hFFFF_1234, 1'b0);
    pop_check("R2 mono16", 24'h123400, 24'h123400);
    cfg(1'b0, 1'b0, 1'b0, 6'd8, 2'd0, 2'd1);
    write(32'hFFFF_FF5A, 1'b0);
    pop_check("R6 pad8", 24'h5A0000, 24'h5A0000);
    cfg(1'b0, 1'b0, 1'b0, 6'd18, 2'd2, 2'd1);
    write(32'h00FF_FFFF, 1'b0);
    pop_check("R6 mask18", 24'hFFFFC0, 24'hFFFFC0);
  endtask

  task automatic t_toggle();
    cfg(1'b1, 1'b1, 1'b0, 6'd24, 2'd2, 2'd1);
    write(32'h00AB_CDEF, 1'b1);
    check("R3 no pair after ch1", {31'b0, out_valid}, 32'd0);
    write(32'h0012_3456, 1'b0);
    pop_check("R3 R4 big endian pair", 24'hEFCDAB, 24'h563412);
  endtask

  task automatic t_justify();
    cfg(1'b0, 1'b0, 1'b1, 6'd20, 2'd3, 2'd1);
    write(32'hABCD_E000, 1'b0);
    pop_check("R5 msb20", 24'hABCDE0, 24'hABCDE0);
    cfg(1'b0, 1'b0, 1'b0, 6'd32, 2'd3, 2'd1);
    write(32'h1234_5678, 1'b0);
    pop_check("R6 trunc32", 24'h123456, 24'h123456);
  endtask

  task automatic t_indexed();
    cfg(1'b1, 1'b0, 1'b0, 6'd8, 2'd0, 2'd0);
    write(32'h0000_0011, 1'b0);
    check("R7 no pair after ch1", {31'b0, out_valid}, 32'd0);
    write(32'h0000_0022, 1'b1);
    pop_check("R7 indexed pair", 24'h110000, 24'h220000);
  endtask

  task automatic t_interleaved();
    cfg(1'b1, 1'b0, 1'b0, 6'd16, 2'd1, 2'd2);
    write(32'hBBBB_AAAA, 1'b0);
    pop_check("R8 interleaved le", 24'hAAAA00, 24'hBBBB00);
    cfg(1'b1, 1'b1, 1'b0, 6'd16, 2'd1, 2'd2);
    write(32'h2211_4433, 1'b0);
    pop_check("R8 interleaved be", 24'h334400, 24'h112200);
  endtask

  task automatic t_fill();
    cfg(1'b0, 1'b0, 1'b0, 6'd16, 2'd1, 2'd1);
    cfg_chunk = 4'd2;
    write(32'h0000_0001, 1'b0);
    write(32'h0000_0002, 1'b0);
    check("R9 chunk at 2 free", {31'b0, chunk_ready}, 32'd1);
    write(32'h0000_0003, 1'b0);
    check("R9 chunk at 1 free", {31'b0, chunk_ready}, 32'd0);
    write(32'h0000_0004, 1'b0);
    check("R9 full", {31'b0, fifo_full}, 32'd1);
    check("R9 tx_ready low", {31'b0, tx_ready}, 32'd0);
    write(32'h0000_0005, 1'b0);
    check("R10 overflow set", {31'b0, overflow}, 32'd1);
    @(negedge clk);
    check("R13 held ch1", {8'b0, out_ch1}, 32'h000100);
    for (int i = 1; i <= 4; i++)
      pop_check("R9 R10 order", 24'(i << 8), 24'(i << 8));
    check("R9 empty", {31'b0, fifo_empty}, 32'd1);
    check("R10 sticky", {31'b0, overflow}, 32'd1);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check("R12 underrun pulse", {31'b0, underrun}, 32'd1);
    @(negedge clk);
    check("R12 underrun gone", {31'b0, underrun}, 32'd0);
  endtask

  task automatic t_clear();
    cfg(1'b1, 1'b0, 1'b0, 6'd16, 2'd1, 2'd1);
    write(32'h0000_A00A, 1'b0);
    write(32'h0000_B00B, 1'b0);
    write(32'h0000_C00C, 1'b0);
    check("R11 pre clear valid", {31'b0, out_valid}, 32'd1);
    fifo_clear = 1'b1;
    @(negedge clk);
    fifo_clear = 1'b0;
    check("R11 cleared empty", {31'b0, fifo_empty}, 32'd1);
    check("R11 overflow cleared", {31'b0, overflow}, 32'd0);
    write(32'h0000_D00D, 1'b0);
    write(32'h0000_E00E, 1'b0);
    pop_check("R11 pointer reset", 24'hD00D00, 24'hE00E00);
  endtask

  initial begin
    #(5.0 * 20000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mono();
    t_toggle();
    t_justify();
    t_indexed();
    t_interleaved();
    t_fill();
    t_clear();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule